// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter (Standard and Left-Justified Framing)

This block is the sending end of a stereo serial audio link, and it runs as the link master. A sample source offers left and right sample words through a valid/ready handshake. An external clock generator supplies a one-cycle enable pulse for every bit-clock period. Each pulse stands for the bit clock's falling edge, so the receiver can sample the data line on the rising edge. On each pulse the block drives one bit onto the data line, and it also drives the left/right word clock.

Three settings are sampled at every frame boundary:
- The framing: either the standard one-bit-delayed inter-IC-sound layout or the MSB-justified layout.
- The channel width: 8 or 16 bits.
- The frame length: 16, 32 or 48 bit periods.

Both framings use the same datapath. The standard framing is the justified bit stream delayed by one bit period. If no new pair is waiting at a frame boundary, the previous pair is sent again and a one-cycle underrun pulse is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset, `sdOut`, `lrOut`, `underrun` and `inReady` are all 0.
- R2: `inReady` is high only in a cycle where `bitEn` is high and the slot counter is at frame start (slot 0). A pair is taken in a cycle where both `inValid` and `inReady` are high.
- R3: `sdOut` and `lrOut` change only in the cycle that follows a `bitEn` pulse.
- R4: `cfgFrame` selects the frame length: 0 gives 16 bit periods, 1 gives 32, and 2 or 3 give 48. The first half of each frame carries the left word and the second half carries the right word.
- R5: Words are sent MSB first. With `cfgWide`=0 the channel uses bits [7:0] of the input word; with `cfgWide`=1 it uses bits [15:0]. Any slot of a half after the last word bit is sent as 0. If the word is longer than the half, only its leading bits are sent.
- R6: With `cfgJust`=1 (MSB-justified), a word's MSB is sent in the first slot of its half. `lrOut` is 1 during the left half and 0 during the right half.
- R7: With `cfgJust`=0 (standard), `lrOut` is 0 during the left half and 1 during the right half. The data stream is delayed by one slot: the MSB is sent in the second slot of a half, and the first slot of a half carries the bit from the last slot of the half before it, including across a frame boundary.
- R8: If `inValid` is low at a frame boundary, the previous pair is sent again. In that case `underrun` is high for exactly the one clock cycle after that boundary pulse and is low at all other times.
- R9: Changes to `cfgJust`, `cfgWide` and `cfgFrame` in the middle of a frame have no effect until the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle pulse per bit-clock period (falling edge) |
| cfgJust | input | 1 | 1 = MSB-justified framing, 0 = standard framing |
| cfgWide | input | 1 | 1 = 16-bit channels, 0 = 8-bit channels |
| cfgFrame | input | 2 | Frame length code: 0 = 16, 1 = 32, 2 or 3 = 48 bit periods |
| inValid | input | 1 | A sample pair is offered |
| inReady | output | 1 | The pair is taken in this cycle if it is valid |
| inLeft | input | 16 | Left channel sample |
| inRight | input | 16 | Right channel sample |
| sdOut | output | 1 | Serial data line |
| lrOut | output | 1 | Left/right word clock |
| underrun | output | 1 | One-cycle pulse when a pair was repeated |

## Verification
The checker module tests on every cycle:
- `inReady` appears only alongside a bit pulse.
- The data line and word clock never move without a preceding pulse.
- `underrun` lasts one cycle and always follows a boundary that had no valid pair.

Some behaviours can only be shown by the bench's frame scenarios, which predict the data line slot by slot:
- The bit order, width truncation and zero padding.
- The one-slot delay in standard framing and its spill across frame boundaries.
- The word clock polarity in each framing.
- Repetition of the previous pair on underrun.
- Deferral of mid-frame configuration changes.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;
  localparam int SLOT_W  = 6;   // holds slot numbers up to 47
  localparam int HALF_S  = 8;
  localparam int HALF_M  = 16;
  localparam int HALF_L  = 24;

  typedef enum logic [1:0] {
    FRM_16 = 2'd0,
    FRM_32 = 2'd1,
    FRM_48 = 2'd2,
    FRM_48B = 2'd3
  } frameCodeT;

  typedef struct packed {
    logic              adv;        // bit period advance
    logic              load;       // take new pair this period
    logic              rightHalf;  // current slot in right half
    logic [SLOT_W-1:0] slot;       // slot index within half
    logic              fmtJust;    // effective framing for this frame
    logic              wide;       // effective width for this frame
  } strobeT;
endpackage

// File: rtl/audio_ser_ctrl.sv
module audio_ser_ctrl
  import audio_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       inValid,
  input  logic       cfgJust,
  input  logic       cfgWide,
  input  logic [1:0] cfgFrame,
  output logic       inReady,
  output logic       underrun,
  output strobeT     stb
);
  logic [SLOT_W-1:0] pos;
  logic [SLOT_W-1:0] halfLen;
  logic [SLOT_W-1:0] frameLast;
  logic              justQ;
  logic              wideQ;
  logic [1:0]        frameQ;
  logic              boundary;
  logic              effJust;
  logic              effWide;
  logic [1:0]        effFrame;
  logic              rightHalf;

  always_comb begin
    boundary = bitEn && (pos == '0);
    effJust  = boundary ? cfgJust  : justQ;
    effWide  = boundary ? cfgWide  : wideQ;
    effFrame = boundary ? cfgFrame : frameQ;
    unique case (frameCodeT'(effFrame))
      FRM_16:  halfLen = SLOT_W'(HALF_S);
      FRM_32:  halfLen = SLOT_W'(HALF_M);
      default: halfLen = SLOT_W'(HALF_L);
    endcase
    frameLast = SLOT_W'((halfLen << 1) - 1'b1);
    rightHalf = (pos >= halfLen);
  end

  assign inReady       = boundary;
  assign stb.adv       = bitEn;
  assign stb.load      = boundary && inValid;
  assign stb.rightHalf = rightHalf;
  assign stb.slot      = rightHalf ? (pos - halfLen) : pos;
  assign stb.fmtJust   = effJust;
  assign stb.wide      = effWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos      <= '0;
      justQ    <= 1'b0;
      wideQ    <= 1'b0;
      frameQ   <= 2'd0;
      underrun <= 1'b0;
    end else begin
      underrun <= boundary && !inValid;
      if (bitEn) begin
        pos <= (pos == frameLast) ? '0 : pos + 1'b1;
      end
      if (boundary) begin
        justQ  <= cfgJust;
        wideQ  <= cfgWide;
        frameQ <= cfgFrame;
      end
    end
  end
endmodule

// File: rtl/audio_ser_dp.sv
module audio_ser_dp
  import audio_ser_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic              sdOut,
  output logic              lrOut
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] leftQ;
  logic [DATA_W-1:0] rightQ;
  logic [DATA_W-1:0] curWord;
  logic [IDX_W-1:0]  bitIdx;
  logic              rawBit;
  logic              prevRaw;
  int                width;

  always_comb begin
    if (stb.rightHalf) curWord = stb.load ? inRight : rightQ;
    else               curWord = stb.load ? inLeft  : leftQ;
    width  = stb.wide ? DATA_W : NARROW_W;
    bitIdx = IDX_W'(width - 1 - int'(stb.slot));
    rawBit = (int'(stb.slot) < width) ? curWord[bitIdx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftQ   <= '0;
      rightQ  <= '0;
      prevRaw <= 1'b0;
      sdOut   <= 1'b0;
      lrOut   <= 1'b0;
    end else if (stb.adv) begin
      prevRaw <= rawBit;
      sdOut   <= stb.fmtJust ? rawBit : prevRaw;
      lrOut   <= stb.fmtJust ? !stb.rightHalf : stb.rightHalf;
      if (stb.load) begin
        leftQ  <= inLeft;
        rightQ <= inRight;
      end
    end
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              cfgJust,
  input  logic              cfgWide,
  input  logic [1:0]        cfgFrame,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  output logic              sdOut,
  output logic              lrOut,
  output logic              underrun
);
  strobeT stb;

  audio_ser_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .inValid  (inValid),
    .cfgJust  (cfgJust),
    .cfgWide  (cfgWide),
    .cfgFrame (cfgFrame),
    .inReady  (inReady),
    .underrun (underrun),
    .stb      (stb)
  );

  audio_ser_dp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inLeft  (inLeft),
    .inRight (inRight),
    .sdOut   (sdOut),
    .lrOut   (lrOut)
  );
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic inValid,
  input logic inReady,
  input logic sdOut,
  input logic lrOut,
  input logic underrun
);
  AST_READY_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> bitEn); // R2

  AST_LINES_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(sdOut) && $stable(lrOut))); // R3

  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun); // R8

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(inReady && !inValid)); // R8
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (.*);

// File: tb/tb_audio_ser_tx.sv
module tb_audio_ser_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        cfgJust = 1'b0;
  logic        cfgWide = 1'b0;
  logic [1:0]  cfgFrame = 2'd0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inLeft = '0;
  logic [15:0] inRight = '0;
  logic        sdOut;
  logic        lrOut;
  logic        underrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit bPrevRaw = 1'b0;
  logic [15:0] bL = '0;
  logic [15:0] bR = '0;

  always #10 clk = ~clk;

  audio_ser_tx dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .cfgJust(cfgJust), .cfgWide(cfgWide),
    .cfgFrame(cfgFrame), .inValid(inValid), .inReady(inReady), .inLeft(inLeft),
    .inRight(inRight), .sdOut(sdOut), .lrOut(lrOut), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int halfOf(input logic [1:0] code);
    if (code == 2'd0) return 8;
    if (code == 2'd1) return 16;
    return 24;
  endfunction

  function automatic bit expRaw(input bit wide, input int half, input int p,
                                input logic [15:0] l, input logic [15:0] r);
    int n = wide ? 16 : 8;
    bit h = (p >= half);
    int s = h ? p - half : p;
    logic [15:0] w = h ? r : l;
    if (s < n) return w[n-1-s];
    return 1'b0;
  endfunction

  task automatic runFrame(input bit just, input bit wide, input logic [1:0] frm,
                          input bit valid, input logic [15:0] l, input logic [15:0] r,
                          input bit glitch);
    int half = halfOf(frm);
    cfgJust = just; cfgWide = wide; cfgFrame = frm;
    inValid = valid; inLeft = l; inRight = r;
    if (valid) begin bL = l; bR = r; end
    for (int p = 0; p < 2*half; p++) begin
      bit raw;
      bit expSd;
      bit expLr;
      string sdReq;
      bitEn = 1'b1;
      #1;
      chk(inReady == (p == 0), "R2", int'(inReady), int'(p == 0));
      @(negedge clk);
      bitEn = 1'b0;
      if (p == 0) begin
        inValid = 1'b0;
        inLeft = 16'($urandom);
        inRight = 16'($urandom);
      end
      raw   = expRaw(wide, half, p, bL, bR);
      expSd = just ? raw : bPrevRaw;
      expLr = just ? (p < half) : (p >= half);
      if (glitch) sdReq = "R9";
      else if (just) sdReq = "R6";
      else sdReq = "R7";
      chk(sdOut == expSd, sdReq, int'(sdOut), int'(expSd));
      chk(lrOut == expLr, glitch ? "R9" : "R4", int'(lrOut), int'(expLr));
      chk(underrun == (p == 0 && !valid), "R8", int'(underrun), int'(p == 0 && !valid));
      bPrevRaw = raw;
      if (glitch && p == 1) begin
        cfgJust = ~just; cfgWide = ~wide; cfgFrame = frm + 2'd1;
      end
      @(negedge clk);
      chk(underrun == 1'b0, "R8", int'(underrun), 0);
      chk(sdOut == expSd && lrOut == expLr, "R3",
          int'({sdOut, lrOut}), int'({expSd, expLr}));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(sdOut == 1'b0 && lrOut == 1'b0, "R1", int'({sdOut, lrOut}), 0);
    chk(underrun == 1'b0 && inReady == 1'b0, "R1", int'({underrun, inReady}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(sdOut == 1'b0 && lrOut == 1'b0 && underrun == 1'b0, "R1",
        int'({sdOut, lrOut, underrun}), 0);

    // R6: justified, 8-bit in 16-slot frame
    runFrame(1'b1, 1'b0, 2'd0, 1'b1, 16'h12A5, 16'h34C3, 1'b0);
    // R7: standard, 16-bit in 32-slot frame, spill into next frame
    runFrame(1'b0, 1'b1, 2'd1, 1'b1, 16'hF00F, 16'h8001, 1'b0);
    runFrame(1'b0, 1'b1, 2'd1, 1'b1, 16'h0FF1, 16'h7FFE, 1'b0);
    // R5: 16-bit word truncated in 16-slot frame; padding in 48-slot frame
    runFrame(1'b1, 1'b1, 2'd0, 1'b1, 16'hBEEF, 16'hCAFE, 1'b0);
    runFrame(1'b0, 1'b0, 2'd2, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
    runFrame(1'b1, 1'b1, 2'd3, 1'b1, 16'hA5A5, 16'h5A5A, 1'b0);
    // R8: underrun repeats the previous pair
    runFrame(1'b1, 1'b1, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b0);
    runFrame(1'b0, 1'b1, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b0);
    // R9: mid-frame configuration changes deferred
    runFrame(1'b1, 1'b0, 2'd1, 1'b1, 16'h00C6, 16'h0039, 1'b1);
    runFrame(1'b0, 1'b1, 2'd0, 1'b1, 16'h9137, 16'h6C2B, 1'b1);

    for (int i = 0; i < 30; i++) begin
      runFrame(1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 4) != 0,
               16'($urandom), 16'($urandom), ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule